// File: doc/BRIEF.md
# Character LCD Parallel Write Engine

This block carries out one 8-bit write at a time to a character LCD controller over a parallel bus made of a register-select line, a read/write line, an enable strobe and eight data lines. An upstream sequencer hands it a request through a valid/ready handshake. Each request holds a one-bit selector (0 = instruction byte, 1 = display data byte) and the byte itself. The engine then drives the bus through four timed phases, each with a minimum length. First it drives the register-select line and waits out the setup time. Next it raises the enable strobe with the byte on the data lines for the minimum pulse width. The controller latches the byte when enable falls. The engine then keeps register-select steady for the hold time. Last, it waits out the rest of the minimum cycle time before it accepts the next request.

Back-pressure: `in_ready` is high only while the engine is idle. A request is taken on a rising clock edge where both `in_valid` and `in_ready` are high. The engine stores the selector and the byte at that edge, so the source may change or drop them from the next cycle on. While a write is in progress, `in_valid` is ignored. A source that keeps `in_valid` high is served as soon as the engine returns to idle. Power-on command ordering and the choice of what to display belong to the upstream sequencer.

Every phase length comes from a clock-frequency parameter in MHz and a nanosecond minimum, rounded up to whole cycles. With the defaults (200 MHz, 140/450/10/1000 ns), the phase lengths are 28, 90, 2 and 80 cycles.

Top module: `char_lcd_writer`

## Requirements
- R1: `in_ready` is 1 exactly when the engine is idle. A write is accepted on a clock edge with `in_valid` = 1 and `in_ready` = 1, and `in_ready` stays 0 from the next cycle until the write completes. With no request, E never rises.
- R2: From the cycle after acceptance, `lcd_rs` carries the request's selector (0 = instruction, 1 = data) for N_SU cycles before E rises, and keeps it while E is high.
- R3: `lcd_e` is high for exactly N_PW consecutive cycles per write, starting N_SU cycles after acceptance. `lcd_db` shows the accepted byte from the first cycle of that pulse and does not change while E is high.
- R4: After E falls, `lcd_rs` keeps its value for N_HD cycles and then returns to 0. `lcd_db` keeps the last byte written until the next pulse or a reset.
- R5: `done` is a one-cycle pulse in the first cycle after N_SU + N_PW + N_HD + N_REST busy cycles. `in_ready` returns to 1 in that same cycle.
- R6: N_SU, N_PW, N_HD and N_CYC are each ceil(ns × CLK_MHZ / 1000) with a floor of 1. N_REST = N_CYC − (N_SU + N_PW + N_HD) when that difference is positive, and 1 otherwise. The defaults give 28, 90, 2, 200 and 80 cycles.
- R7: `lcd_rw` is 0 at all times.
- R8: The selector and byte are stored at acceptance. Input changes after the accepting edge do not alter `lcd_rs` or `lcd_db` for that write.
- R9: A request presented while the engine is busy is ignored. After the running write completes, no second pulse follows, and `lcd_db` still holds the first byte.
- R10: A synchronous active-low reset puts the engine in idle: `lcd_e` = 0, `lcd_rs` = 0, `lcd_db` = 0, `in_ready` = 1, `done` = 0. This holds even when reset arrives in the middle of the enable pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency given by CLK_MHZ |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine idle and able to take a request |
| in_rs | input | 1 | Selector: 0 instruction, 1 display data |
| in_byte | input | 8 | Byte to write |
| lcd_rs | output | 1 | LCD register-select line |
| lcd_rw | output | 1 | LCD read/write line, held at 0 (write) |
| lcd_e | output | 1 | LCD enable strobe; the byte is latched on its falling edge |
| lcd_db | output | 8 | LCD data lines |
| done | output | 1 | One-cycle pulse when a write's full cycle has elapsed |

## Verification
The main function is exercised with a set of requests that mixes instruction and data selectors with bytes of all zeros, all ones and assorted patterns. For each write, the bench compares the whole bus waveform cycle by cycle against a schedule it computes from the nanosecond minimums. This separates a wrong selector, a phase that is off by one in either direction, a byte that is late or unstable, and a `done` or `in_ready` at the wrong cycle. After each acceptance the bench scrambles the inputs, which exposes a design that reads its inputs directly instead of storing them. Directed cases then cover the idle state with no request, a request held while the engine is busy, and a reset in the middle of the enable pulse.

// File: rtl/lcdw_pkg.sv
`timescale 1ns/1ps
package lcdw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_REST  = 3'd4
  } phase_e;

  // Cycles needed to cover a minimum of ns nanoseconds at mhz MHz, rounded up, at least 1.
  function automatic int ns_to_cycles(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcdw_interval_timer.sv
`timescale 1ns/1ps
module lcdw_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lcdw_sequencer.sv
`timescale 1ns/1ps
module lcdw_sequencer
  import lcdw_pkg::*;
#(
  parameter int W      = 8,
  parameter int N_SU   = 1,
  parameter int N_PW   = 1,
  parameter int N_HD   = 1,
  parameter int N_REST = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         tmr_expired,
  output phase_e       phase_q,
  output phase_e       phase_d,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  output logic         accept,
  output logic         in_ready
);

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (in_valid) begin
          phase_d  = PH_SETUP;
          tmr_load = 1'b1;
          tmr_val  = W'(N_SU - 1);
        end
      end
      PH_SETUP: begin
        if (tmr_expired) begin
          phase_d  = PH_PULSE;
          tmr_load = 1'b1;
          tmr_val  = W'(N_PW - 1);
        end
      end
      PH_PULSE: begin
        if (tmr_expired) begin
          phase_d  = PH_HOLD;
          tmr_load = 1'b1;
          tmr_val  = W'(N_HD - 1);
        end
      end
      PH_HOLD: begin
        if (tmr_expired) begin
          phase_d  = PH_REST;
          tmr_load = 1'b1;
          tmr_val  = W'(N_REST - 1);
        end
      end
      PH_REST: begin
        if (tmr_expired) begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign in_ready = (phase_q == PH_IDLE);
  assign accept   = in_ready && in_valid;

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R5
  rest_leads_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) && !$stable(phase_q) |-> $past(phase_q) == PH_REST);

endmodule

// File: rtl/lcdw_pin_driver.sv
`timescale 1ns/1ps
module lcdw_pin_driver
  import lcdw_pkg::*;
#(
  parameter int N_PW = 1,
  localparam int RUN_W = $clog2(N_PW + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       in_rs,
  input  logic [7:0] in_byte,
  input  phase_e     phase_q,
  input  phase_e     phase_d,
  output logic       lcd_rs,
  output logic       lcd_e,
  output logic [7:0] lcd_db,
  output logic       done
);

  logic [7:0]       byte_q;
  logic             rs_q;
  logic             e_q;
  logic [7:0]       db_q;
  logic             done_q;
  logic [RUN_W-1:0] e_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      rs_q   <= 1'b0;
      e_q    <= 1'b0;
      db_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (accept) byte_q <= in_byte;
      if (accept) rs_q <= in_rs;
      else if (phase_d == PH_REST || phase_d == PH_IDLE) rs_q <= 1'b0;
      e_q <= (phase_d == PH_PULSE);
      if (phase_d == PH_PULSE && phase_q != PH_PULSE) db_q <= byte_q;
      done_q <= (phase_q == PH_REST) && (phase_d == PH_IDLE);
    end
  end

  // Length of the current enable pulse, used only by the width check.
  always_ff @(posedge clk) begin
    if (!rst_n)   e_run_q <= '0;
    else if (e_q) e_run_q <= e_run_q + 1'b1;
    else          e_run_q <= '0;
  end

  assign lcd_rs = rs_q;
  assign lcd_e  = e_q;
  assign lcd_db = db_q;
  assign done   = done_q;

  // R3
  e_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> e_run_q == RUN_W'(N_PW));

  // R3
  db_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e && $past(lcd_e) |-> $stable(lcd_db));

  // R4
  rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> $stable(lcd_rs));

endmodule

// File: rtl/char_lcd_writer.sv
`timescale 1ns/1ps
module char_lcd_writer
  import lcdw_pkg::*;
#(
  parameter int CLK_MHZ    = 200,
  parameter int T_SETUP_NS = 140,
  parameter int T_PULSE_NS = 450,
  parameter int T_HOLD_NS  = 10,
  parameter int T_CYCLE_NS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_rs,
  input  logic [7:0] in_byte,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db,
  output logic       done
);

  localparam int N_SU   = ns_to_cycles(T_SETUP_NS, CLK_MHZ);
  localparam int N_PW   = ns_to_cycles(T_PULSE_NS, CLK_MHZ);
  localparam int N_HD   = ns_to_cycles(T_HOLD_NS, CLK_MHZ);
  localparam int N_CYC  = ns_to_cycles(T_CYCLE_NS, CLK_MHZ);
  localparam int N_USED = N_SU + N_PW + N_HD;
  localparam int N_REST = (N_CYC > N_USED) ? (N_CYC - N_USED) : 1;
  localparam int N_MAX  = max_of2(max_of2(N_SU, N_PW), max_of2(N_HD, N_REST));
  localparam int CNT_W  = $clog2(N_MAX + 1);

  phase_e             phase_q;
  phase_e             phase_d;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_expired;
  logic               accept;

  lcdw_interval_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  lcdw_sequencer #(
    .W(CNT_W), .N_SU(N_SU), .N_PW(N_PW), .N_HD(N_HD), .N_REST(N_REST)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .tmr_expired (tmr_expired),
    .phase_q     (phase_q),
    .phase_d     (phase_d),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (accept),
    .in_ready    (in_ready)
  );

  lcdw_pin_driver #(.N_PW(N_PW)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .in_rs   (in_rs),
    .in_byte (in_byte),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .lcd_rs  (lcd_rs),
    .lcd_e   (lcd_e),
    .lcd_db  (lcd_db),
    .done    (done)
  );

  assign lcd_rw = 1'b0;

  // R1
  e_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> !in_ready);

  // R5
  done_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready && !$past(in_ready));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/char_lcd_writer_tb.sv
`timescale 1ns/1ps
module char_lcd_writer_tb;

  // R6: expected phase lengths from the nanosecond minimums at 200 MHz
  localparam int MHZ   = 200;
  localparam int E_SU  = (140 * MHZ + 999) / 1000;
  localparam int E_PW  = (450 * MHZ + 999) / 1000;
  localparam int E_HD  = (10 * MHZ + 999) / 1000;
  localparam int E_CYC = (1000 * MHZ + 999) / 1000;
  localparam int E_RST = (E_CYC > E_SU + E_PW + E_HD) ? E_CYC - (E_SU + E_PW + E_HD) : 1;
  localparam int TOT   = E_SU + E_PW + E_HD + E_RST;

  // {selector, byte}
  localparam logic [8:0] VEC [6] = '{9'h038, 9'h00C, 9'h141, 9'h1FF, 9'h000, 9'h0C0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_rs = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       lcd_rs, lcd_rw, lcd_e, done;
  logic [7:0] lcd_db;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  char_lcd_writer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_rs(in_rs), .in_byte(in_byte), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_e(lcd_e), .lcd_db(lcd_db), .done(done)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // One write: drive at a falling edge, scramble inputs after acceptance, compare every cycle.
  task automatic run_write(input logic rs, input logic [7:0] b, input logic [7:0] prev_db);
    int bad_rs = 0, bad_e = 0, bad_db = 0, bad_rdy = 0, bad_done = 0, bad_rw = 0;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1 ready before request", in_ready, 1);
    in_valid = 1'b1; in_rs = rs; in_byte = b;
    for (int n = 1; n <= TOT + 1; n++) begin
      @(negedge clk);
      if (n == 1) begin
        in_valid = 1'b0; in_rs = ~rs; in_byte = ~b;   // R8: later input changes
      end
      if (lcd_rs !== ((n <= E_SU + E_PW + E_HD) ? rs : 1'b0)) bad_rs++;
      if (lcd_e !== ((n > E_SU && n <= E_SU + E_PW) ? 1'b1 : 1'b0)) bad_e++;
      if (lcd_db !== ((n > E_SU) ? b : prev_db)) bad_db++;
      if (in_ready !== ((n > TOT) ? 1'b1 : 1'b0)) bad_rdy++;
      if (done !== ((n == TOT + 1) ? 1'b1 : 1'b0)) bad_done++;
      if (lcd_rw !== 1'b0) bad_rw++;
    end
    chk(bad_rs == 0, "R2 R4 R8 rs waveform bad cycles", bad_rs, 0);
    chk(bad_e == 0, "R3 R6 enable waveform bad cycles", bad_e, 0);
    chk(bad_db == 0, "R3 R4 R8 data waveform bad cycles", bad_db, 0);
    chk(bad_rdy == 0, "R1 ready waveform bad cycles", bad_rdy, 0);
    chk(bad_done == 0, "R5 done waveform bad cycles", bad_done, 0);
    chk(bad_rw == 0, "R7 rw nonzero cycles", bad_rw, 0);
  endtask

  initial begin
    logic [7:0] last_db;
    int e_seen;
    repeat (3) @(negedge clk);
    // R10: state after reset
    chk(lcd_e === 1'b0, "R10 reset e", lcd_e, 0);
    chk(lcd_rs === 1'b0, "R10 reset rs", lcd_rs, 0);
    chk(lcd_db === 8'h00, "R10 reset db", lcd_db, 0);
    chk(in_ready === 1'b1, "R10 reset ready", in_ready, 1);
    chk(done === 1'b0, "R10 reset done", done, 0);
    rst_n = 1'b1;

    // R1: idle with no request, no strobe
    e_seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (lcd_e !== 1'b0) e_seen++;
    end
    chk(e_seen == 0, "R1 no strobe without request", e_seen, 0);

    last_db = 8'h00;
    for (int v = 0; v < 6; v++) begin
      run_write(VEC[v][8], VEC[v][7:0], last_db);
      last_db = VEC[v][7:0];
    end

    // R9: request held while busy is ignored
    @(negedge clk);
    in_valid = 1'b1; in_rs = 1'b1; in_byte = 8'h55;
    @(negedge clk);
    in_byte = 8'hAA; in_rs = 1'b0;                  // stays valid while busy
    for (int n = 2; n <= TOT; n++) @(negedge clk);
    in_valid = 1'b0;
    e_seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (lcd_e !== 1'b0) e_seen++;
    end
    chk(e_seen == 0, "R9 no second pulse", e_seen, 0);
    chk(lcd_db === 8'h55, "R9 db keeps first byte", lcd_db, 8'h55);
    chk(in_ready === 1'b1, "R9 idle afterwards", in_ready, 1);

    // R10: reset in the middle of the enable pulse
    @(negedge clk);
    in_valid = 1'b1; in_rs = 1'b1; in_byte = 8'h3C;
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 2; n <= E_SU + 5; n++) @(negedge clk);
    chk(lcd_e === 1'b1, "R3 pulse before abort", lcd_e, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(lcd_e === 1'b0, "R10 abort e", lcd_e, 0);
    chk(lcd_rs === 1'b0, "R10 abort rs", lcd_rs, 0);
    chk(lcd_db === 8'h00, "R10 abort db", lcd_db, 0);
    chk(in_ready === 1'b1, "R10 abort ready", in_ready, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    run_write(1'b0, 8'h01, 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule